// File: doc/BRIEF.md
# I2C Start Condition Generator and Bus Condition Monitor

This block sits beside the byte engine of a two-wire serial controller that can work as bus master or as slave. It watches the shared clock and data lines and keeps two sticky status flags: one for the last start condition seen on the bus and one for the last stop condition. Either device can have caused the condition. Because each condition clears the other flag, exactly one of the two flags is set at any time. After reset the stop flag is set, so the bus is taken to be free.

Software asks for a start condition with a one-cycle request strobe. The request stays pending until the stop flag shows a free bus and both filtered lines are high. The block then pulls the data line low while the clock line is still high. It keeps only data low for a programmable number of system clocks, then pulls the clock line low as well for the same count. In the next cycle it releases data, keeps clock low, and pulses a done strobe. At that point the byte engine takes over the clock line. The block only ever asserts drive-low enables; the real line level is the wired-AND of every driver with a pull-up.

Both line inputs pass through a two-flop synchronizer. A filter then updates its output only when three consecutive synchronized samples agree. Conditions are detected on the filtered levels.

Top module: `i2c_start_ctrl`

## Requirements
- R1: After reset, both drive-low enables are 0, `start_pending` is 0, `start_done` is 0, `start_seen` is 0 and `stop_seen` is 1.
- R2: If the data line falls while the clock line is high and both levels are stable, `start_seen` becomes 1 and `stop_seen` becomes 0 within 8 clock cycles.
- R3: If the data line rises while the clock line is high, `stop_seen` becomes 1 and `start_seen` becomes 0 within 8 clock cycles. Exactly one of the two flags is 1 at all times.
- R4: A change of the data line while the clock line is low leaves both flags unchanged. A change of the clock line also leaves both flags unchanged.
- R5: A pulse on a line that lasts fewer than 3 clock cycles is ignored: a 2-cycle low pulse on the data line while the clock line is high does not change the flags.
- R6: A request made while `stop_seen` is 0 drives nothing and keeps `start_pending` at 1. It is carried out after a stop condition is detected.
- R7: A start is issued as follows, with L = max(`hold_count`, 4). First the data drive alone is active for L cycles. Then both drives are active for L cycles. Then the clock drive alone is active for one cycle with `start_done` high. After that no drive is active.
- R8: `start_pending` reads 0 from the `start_done` cycle onward. The start condition the block itself creates sets `start_seen` and clears `stop_seen`.
- R9: A request is not launched while either filtered line is low, for example while another device holds the clock line low. It is launched once the line is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_req_set | input | 1 | One-cycle strobe that sets the start request bit |
| hold_count | input | HOLD_W | Hold time of each start phase in clocks (values below 4 act as 4) |
| scl_in | input | 1 | Sensed level of the clock line |
| sda_in | input | 1 | Sensed level of the data line |
| scl_drive_low | output | 1 | Enable that pulls the clock line low |
| sda_drive_low | output | 1 | Enable that pulls the data line low |
| start_pending | output | 1 | Start request bit |
| start_seen | output | 1 | Sticky flag: start condition detected |
| stop_seen | output | 1 | Sticky flag: stop condition detected |
| start_done | output | 1 | One-cycle pulse when the block hands the bus to the byte engine |

## Verification
The properties on the detector's event wires and on the one-hot flags assume that every real line transition settles longer than the filter window. They also assume that only one line changes within a window, so the two filtered levels keep the order of the raw ones. The bench meets this by holding every line level it drives for ten cycles. The single short pulse it makes on purpose is the glitch case. The pending-clear property assumes that no new request strobe arrives in the done cycle, and the bench only raises a request while no start is in progress.

// File: rtl/i2c_sc_pkg.sv
package i2c_sc_pkg;

  typedef enum logic [1:0] {
    GEN_IDLE,
    GEN_SDA,
    GEN_BOTH,
    GEN_HAND
  } gen_state_e;

  // Effective phase length: programmed count, never below the floor that
  // keeps every phase longer than the glitch filter window.
  function automatic int unsigned hold_len(input int unsigned prog,
                                           input int unsigned floor_val);
    return (prog < floor_val) ? floor_val : prog;
  endfunction

endpackage

// File: rtl/i2c_glitch_filter.sv
module i2c_glitch_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_TAPS   = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic filt
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [FILT_TAPS-1:0]   hist_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      hist_q <= '1;
      filt   <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], raw};
      hist_q <= {hist_q[FILT_TAPS-2:0], sync_q[SYNC_STAGES-1]};
      if (&hist_q)       filt <= 1'b1;
      else if (~|hist_q) filt <= 1'b0;
    end
  end

endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic start_evt,
  output logic stop_evt,
  output logic start_seen,
  output logic stop_seen
);

  logic scl_prev, sda_prev;

  assign start_evt = scl_prev & scl_f & sda_prev & ~sda_f;
  assign stop_evt  = scl_prev & scl_f & ~sda_prev & sda_f;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_prev   <= 1'b1;
      sda_prev   <= 1'b1;
      start_seen <= 1'b0;
      stop_seen  <= 1'b1;
    end else begin
      scl_prev <= scl_f;
      sda_prev <= sda_f;
      if (start_evt) begin
        start_seen <= 1'b1;
        stop_seen  <= 1'b0;
      end else if (stop_evt) begin
        start_seen <= 1'b0;
        stop_seen  <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/i2c_start_gen.sv
module i2c_start_gen
  import i2c_sc_pkg::*;
#(
  parameter int HOLD_W   = 8,
  parameter int MIN_HOLD = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_req_set,
  input  logic [HOLD_W-1:0] hold_count,
  input  logic              stop_seen,
  input  logic              bus_idle,
  output logic              scl_drive_low,
  output logic              sda_drive_low,
  output logic              start_pending,
  output logic              start_done
);

  gen_state_e        state_q;
  logic [HOLD_W-1:0] cnt_q;
  logic [HOLD_W-1:0] len_q;
  logic [HOLD_W-1:0] len_now;
  logic              launch;
  logic              pend_clr;

  assign len_now  = HOLD_W'(hold_len(int'(hold_count), MIN_HOLD));
  assign launch   = (state_q == GEN_IDLE) && start_pending && stop_seen && bus_idle;
  assign pend_clr = (state_q == GEN_BOTH) && (cnt_q == '0);

  assign sda_drive_low = (state_q == GEN_SDA) || (state_q == GEN_BOTH);
  assign scl_drive_low = (state_q == GEN_BOTH) || (state_q == GEN_HAND);
  assign start_done    = (state_q == GEN_HAND);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_pending <= 1'b0;
    end else begin
      start_pending <= (start_pending & ~pend_clr) | start_req_set;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= GEN_IDLE;
      cnt_q   <= '0;
      len_q   <= '0;
    end else begin
      unique case (state_q)
        GEN_IDLE: if (launch) begin
          state_q <= GEN_SDA;
          len_q   <= len_now;
          cnt_q   <= len_now - HOLD_W'(1);
        end
        GEN_SDA: begin
          if (cnt_q == '0) begin
            state_q <= GEN_BOTH;
            cnt_q   <= len_q - HOLD_W'(1);
          end else begin
            cnt_q <= cnt_q - HOLD_W'(1);
          end
        end
        GEN_BOTH: begin
          if (cnt_q == '0) state_q <= GEN_HAND;
          else             cnt_q   <= cnt_q - HOLD_W'(1);
        end
        GEN_HAND: state_q <= GEN_IDLE;
        default:  state_q <= GEN_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/i2c_start_ctrl.sv
module i2c_start_ctrl #(
  parameter int HOLD_W      = 8,
  parameter int MIN_HOLD    = 4,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_TAPS   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_req_set,
  input  logic [HOLD_W-1:0] hold_count,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              scl_drive_low,
  output logic              sda_drive_low,
  output logic              start_pending,
  output logic              start_seen,
  output logic              stop_seen,
  output logic              start_done
);

  localparam int NUM_LINES = 2;
  localparam int SCL_IDX   = 0;
  localparam int SDA_IDX   = 1;

  logic [NUM_LINES-1:0] raw_lines;
  logic [NUM_LINES-1:0] filt_lines;
  logic                 start_evt;
  logic                 stop_evt;
  logic                 bus_idle;

  assign raw_lines = {sda_in, scl_in};
  assign bus_idle  = &filt_lines;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    i2c_glitch_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_TAPS  (FILT_TAPS)
    ) u_filt (
      .clk  (clk),
      .rst_n(rst_n),
      .raw  (raw_lines[g]),
      .filt (filt_lines[g])
    );
  end

  i2c_cond_detect u_det (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_f     (filt_lines[SCL_IDX]),
    .sda_f     (filt_lines[SDA_IDX]),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .start_seen(start_seen),
    .stop_seen (stop_seen)
  );

  i2c_start_gen #(
    .HOLD_W  (HOLD_W),
    .MIN_HOLD(MIN_HOLD)
  ) u_gen (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_req_set(start_req_set),
    .hold_count   (hold_count),
    .stop_seen    (stop_seen),
    .bus_idle     (bus_idle),
    .scl_drive_low(scl_drive_low),
    .sda_drive_low(sda_drive_low),
    .start_pending(start_pending),
    .start_done   (start_done)
  );

endmodule

// File: rtl/i2c_start_ctrl_chk.sv
module i2c_start_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic start_req_set,
  input logic scl_drive_low,
  input logic sda_drive_low,
  input logic start_pending,
  input logic start_seen,
  input logic stop_seen,
  input logic start_done,
  input logic start_evt,
  input logic stop_evt,
  input logic bus_idle
);

  p_flags_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({start_seen, stop_seen}) == 1);

  p_start_sets_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (start_seen && !stop_seen));

  p_stop_sets_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> (stop_seen && !start_seen));

  p_launch_needs_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_drive_low) |-> $past(start_pending && stop_seen));

  p_launch_needs_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_drive_low) |-> $past(bus_idle));

  p_data_before_clock_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_drive_low) |-> $past(sda_drive_low));

  p_done_shape_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start_done |-> (scl_drive_low && !sda_drive_low));

  p_pending_cleared_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start_done && !$past(start_req_set)) |-> !start_pending);

endmodule

bind i2c_start_ctrl i2c_start_ctrl_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_req_set(start_req_set),
  .scl_drive_low(scl_drive_low),
  .sda_drive_low(sda_drive_low),
  .start_pending(start_pending),
  .start_seen   (start_seen),
  .stop_seen    (stop_seen),
  .start_done   (start_done),
  .start_evt    (start_evt),
  .stop_evt     (stop_evt),
  .bus_idle     (bus_idle)
);

// File: tb/i2c_start_ctrl_test.sv
`timescale 1ns/1ps
module i2c_start_ctrl_test;

  localparam int HOLD_W = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start_req_set = 1'b0;
  logic [HOLD_W-1:0] hold_count = '0;
  logic              tb_scl_low = 1'b0;
  logic              tb_sda_low = 1'b0;
  logic              scl_line, sda_line;
  logic              scl_dl, sda_dl, start_pending, start_seen, stop_seen, start_done;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit finished = 0;
  bit exp_start = 0;
  bit exp_stop = 1;

  always #10 clk = ~clk;

  assign scl_line = ~(scl_dl | tb_scl_low);
  assign sda_line = ~(sda_dl | tb_sda_low);

  i2c_start_ctrl #(.HOLD_W(HOLD_W)) uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_req_set(start_req_set),
    .hold_count   (hold_count),
    .scl_in       (scl_line),
    .sda_in       (sda_line),
    .scl_drive_low(scl_dl),
    .sda_drive_low(sda_dl),
    .start_pending(start_pending),
    .start_seen   (start_seen),
    .stop_seen    (stop_seen),
    .start_done   (start_done)
  );

  function automatic int exp_len(input int h);
    return (h > 4) ? h : 4;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Bench drives one line; the model updates the expected flags.
  task automatic bus_set(input bit scl_low, input bit sda_low);
    bit old_scl = !tb_scl_low;
    bit old_sda = !tb_sda_low;
    bit new_scl = !scl_low;
    bit new_sda = !sda_low;
    if (old_scl && new_scl && old_sda && !new_sda) begin exp_start = 1; exp_stop = 0; end
    if (old_scl && new_scl && !old_sda && new_sda) begin exp_start = 0; exp_stop = 1; end
    tb_scl_low = scl_low;
    tb_sda_low = sda_low;
  endtask

  task automatic check_flags(input string req);
    chk({req, " start_seen"}, start_seen, exp_start);
    chk({req, " stop_seen"}, stop_seen, exp_stop);
  endtask

  task automatic request();
    start_req_set = 1'b1;
    @(negedge clk);
    start_req_set = 1'b0;
  endtask

  // Observes one start generated by the block and checks its phases.
  task automatic watch_start(input int h);
    int t = 0;
    int n1 = 0;
    int n2 = 0;
    while (!sda_dl && t < 200) begin @(negedge clk); t++; end
    chk("R7 launch seen", sda_dl, 1);
    while (sda_dl && !scl_dl && n1 < 1000) begin n1++; @(negedge clk); end
    chk("R7 data-only phase length", n1, exp_len(h));
    while (sda_dl && scl_dl && n2 < 1000) begin n2++; @(negedge clk); end
    chk("R7 both-low phase length", n2, exp_len(h));
    chk("R7 done pulse", start_done, 1);
    chk("R7 clock-only in done cycle", {scl_dl, sda_dl}, 2'b10);
    chk("R8 pending cleared", start_pending, 0);
    @(negedge clk);
    chk("R7 released after done", {scl_dl, sda_dl, start_done}, 3'b000);
    exp_start = 1; exp_stop = 0;
    wait_cyc(12);
    check_flags("R8 own start");
  endtask

  task automatic make_stop();
    bus_set(1, tb_sda_low); wait_cyc(10);
    bus_set(1, 1);          wait_cyc(10);
    bus_set(0, 1);          wait_cyc(10);
    bus_set(0, 0);          wait_cyc(10);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1;
      failures++; checks++;
      $display("FAIL watchdog actual=%0d expected=0", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED1C));
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(2);
    // R1 reset state
    chk("R1 drives", {scl_dl, sda_dl}, 0);
    chk("R1 pending", start_pending, 0);
    chk("R1 done", start_done, 0);
    chk("R1 start_seen", start_seen, 0);
    chk("R1 stop_seen", stop_seen, 1);

    // R7 with count below the floor
    hold_count = 0;
    request();
    watch_start(0);

    // R6: request while the bus is not free
    hold_count = 9;
    request();
    wait_cyc(30);
    chk("R6 no drive while busy", {scl_dl, sda_dl}, 0);
    chk("R6 pending held", start_pending, 1);
    bus_set(1, 0); wait_cyc(10);
    bus_set(1, 1); wait_cyc(10);
    bus_set(0, 1); wait_cyc(10);
    bus_set(0, 0);
    watch_start(9);

    // R9: bus free by flag but clock held low by another device
    make_stop();
    check_flags("R3 stop");
    bus_set(1, 0); wait_cyc(10);
    check_flags("R4 clock change");
    hold_count = 5;
    request();
    wait_cyc(30);
    chk("R9 no drive while clock low", {scl_dl, sda_dl}, 0);
    chk("R9 pending held", start_pending, 1);
    bus_set(0, 0);
    watch_start(5);

    // R5: 2-cycle glitch on data while clock high
    make_stop();
    tb_sda_low = 1'b1; wait_cyc(2); tb_sda_low = 1'b0;
    wait_cyc(12);
    check_flags("R5 glitch ignored");

    // Random line activity mixed with own starts
    for (int i = 0; i < 120; i++) begin
      if (exp_stop && !tb_scl_low && !tb_sda_low && ($urandom % 4 == 0)) begin
        int h = $urandom % 24;
        hold_count = HOLD_W'(h);
        request();
        watch_start(h);
      end else begin
        bit cond;
        if ($urandom % 2 == 0) bus_set(!tb_scl_low, tb_sda_low);
        else                   bus_set(tb_scl_low, !tb_sda_low);
        cond = 0;
        wait_cyc(10);
        if (exp_start) check_flags("R2 random");
        else           check_flags("R3 random");
        if (!cond) chk("R4 one-hot", start_seen ^ stop_seen, 1);
      end
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule